// File: doc/BRIEF.md
# Sixteen-Lane Ascending Sort Pipeline

This block orders sixteen unsigned 32-bit keys presented together on one wide bus. It returns the same keys on a second wide bus, smallest first. Internally it is a bitonic network of four stages with ten rounds in all. Each round holds eight compare-exchange cells working side by side. Every cell routes the smaller of its two keys to the lower lane and the larger to the upper lane, so every cell points the same way. The network avoids needing descending cells because the first round of each stage pairs mirrored positions inside each block, rather than the neighbouring position.

Each round ends in a pipeline register. A vector offered with the input strobe therefore appears ten clock cycles later with the output strobe. A new vector may be offered on every cycle, with no gaps required. There is no backpressure. The lane order on both buses is fixed: lane i occupies bits [32*i+31 : 32*i].

Top module: `bsort16_pipe`

## Requirements
- R1: Whenever `out_valid` is high, the 16 keys on `out_keys` are in non-decreasing unsigned order from lane 0 (bits 31:0) up to lane 15 (bits 511:480).
- R2: Whenever `out_valid` is high, the multiset of keys on `out_keys` equals the multiset of the vector that was accepted ten cycles earlier.
- R3: `out_valid` after a rising edge equals `in_valid` as sampled at the rising edge nine edges earlier, so the latency is exactly ten register stages. Idle input cycles reappear as idle output cycles.
- R4: A vector may be accepted on every consecutive cycle. Back-to-back vectors come out on consecutive cycles in arrival order, and each is sorted independently of its neighbours.
- R5: While `rst_n` is low, `out_valid` is low. After any reset, vectors that were in flight when reset arrived are never presented.
- R6: A vector that is already in ascending order comes out unchanged.
- R7: A vector in strictly descending order comes out fully reversed.
- R8: Repeated keys, including a vector where all keys are equal, are kept with their multiplicity. Equal keys may trade lanes.
- R9: Keys compare as unsigned numbers, so 32'h0000_0000 is the smallest key and 32'hFFFF_FFFF is the largest key, even when mixed with keys that have bit 31 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all valid flags |
| in_valid | input | 1 | High when `in_keys` holds a vector to sort this cycle |
| in_keys | input | 512 | Sixteen 32-bit unsigned keys, lane i at bits 32*i+31:32*i |
| out_valid | output | 1 | High when `out_keys` holds a sorted vector |
| out_keys | output | 512 | Sorted keys, smallest in lane 0 |

## Verification
Two functions can land in the same cycle: a new vector entering round zero while an older vector leaves round nine. The bench causes this with bursts of back-to-back vectors and with alternating idle gaps. A behavioural queue model checks that every exiting vector matches its own sorted input, and that the strobe pattern repeats ten edges later. The second overlap is a reset that lands while several vectors are still moving through the rounds. After that reset, the bench expects the output strobe to stay silent, and the model discards whatever it had queued.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    // How a round pairs its lanes
    typedef enum logic {
        RK_MIRROR = 1'b0,   // block of 2*span, lower j against upper (2*span-1-j)
        RK_FIXED  = 1'b1    // block of 2*span, lower j against j+span
    } round_kind_e;

    // Lower lane of compare cell c
    function automatic int pair_lo(input int c, input int span);
        int grp;
        int j;
        grp = c / span;
        j   = c % span;
        return grp * 2 * span + j;
    endfunction

    // Upper lane of compare cell c
    function automatic int pair_hi(input int c, input int span, input round_kind_e kind);
        int grp;
        int j;
        int base;
        grp  = c / span;
        j    = c % span;
        base = grp * 2 * span;
        if (kind == RK_MIRROR) return base + 2 * span - 1 - j;
        return base + j + span;
    endfunction

endpackage

// File: rtl/bsort_cmpx.sv
module bsort_cmpx #(
    parameter int KEY_W = 32
) (
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_b,
    output logic [KEY_W-1:0] key_lo,
    output logic [KEY_W-1:0] key_hi
);

    logic swap;

    always_comb begin
        swap   = key_a > key_b;
        key_lo = swap ? key_b : key_a;
        key_hi = swap ? key_a : key_b;
    end

endmodule

// File: rtl/bsort_round.sv
module bsort_round
    import bsort_pkg::*;
#(
    parameter int          LANES      = 16,
    parameter int          KEY_W      = 32,
    parameter int          SPAN       = 1,
    parameter round_kind_e KIND       = RK_FIXED,
    parameter int          SORTED_RUN = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*KEY_W-1:0] in_keys,
    output logic                   out_valid,
    output logic [LANES*KEY_W-1:0] out_keys
);

    localparam int PAIRS = LANES / 2;
    localparam int SUM_W = KEY_W + $clog2(LANES) + 1;

    typedef struct packed {
        logic                   vld;
        logic [LANES*KEY_W-1:0] keys;
    } round_state_t;

    round_state_t st_d, st_q;

    logic [KEY_W-1:0] lane_key [LANES];
    logic [KEY_W-1:0] lo_key   [PAIRS];
    logic [KEY_W-1:0] hi_key   [PAIRS];

    always_comb begin
        for (int i = 0; i < LANES; i++) lane_key[i] = in_keys[i*KEY_W +: KEY_W];
    end

    for (genvar c = 0; c < PAIRS; c++) begin : g_cell
        localparam int LO_IDX = pair_lo(c, SPAN);
        localparam int HI_IDX = pair_hi(c, SPAN, KIND);
        bsort_cmpx #(.KEY_W(KEY_W)) u_cmpx (
            .key_a  (lane_key[LO_IDX]),
            .key_b  (lane_key[HI_IDX]),
            .key_lo (lo_key[c]),
            .key_hi (hi_key[c])
        );
    end

    always_comb begin
        st_d.vld  = in_valid;
        st_d.keys = in_keys;
        for (int c = 0; c < PAIRS; c++) begin
            st_d.keys[pair_lo(c, SPAN)*KEY_W +: KEY_W]       = lo_key[c];
            st_d.keys[pair_hi(c, SPAN, KIND)*KEY_W +: KEY_W] = hi_key[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_keys  = st_q.keys;

    // ---------------- assertions ----------------
    function automatic logic [SUM_W-1:0] key_sum(input logic [LANES*KEY_W-1:0] v);
        logic [SUM_W-1:0] s;
        s = '0;
        for (int i = 0; i < LANES; i++) s = s + SUM_W'(v[i*KEY_W +: KEY_W]);
        return s;
    endfunction

    function automatic logic runs_ok(input logic [LANES*KEY_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < LANES - 1; i++) begin
            if (((i + 1) % SORTED_RUN) != 0 &&
                v[i*KEY_W +: KEY_W] > v[(i+1)*KEY_W +: KEY_W]) ok = 1'b0;
        end
        return ok;
    endfunction

    assert_vld_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_vld_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_sum_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (key_sum(out_keys) == $past(key_sum(in_keys))));

    if (SORTED_RUN > 1) begin : g_run_chk
        assert_runs_sorted_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> runs_ok(out_keys));
    end

endmodule

// File: rtl/bsort16_pipe.sv
module bsort16_pipe
    import bsort_pkg::*;
#(
    parameter int LOG_LANES = 4,
    parameter int KEY_W     = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [(1<<LOG_LANES)*KEY_W-1:0]     in_keys,
    output logic                                out_valid,
    output logic [(1<<LOG_LANES)*KEY_W-1:0]     out_keys
);

    localparam int LANES  = 1 << LOG_LANES;
    localparam int ROUNDS = LOG_LANES * (LOG_LANES + 1) / 2;

    logic                   vld_bus [ROUNDS+1];
    logic [LANES*KEY_W-1:0] key_bus [ROUNDS+1];

    assign vld_bus[0] = in_valid;
    assign key_bus[0] = in_keys;

    for (genvar s = 0; s < LOG_LANES; s++) begin : g_stage
        for (genvar r = 0; r <= s; r++) begin : g_round
            localparam int          IDX  = s * (s + 1) / 2 + r;
            localparam int          SPAN = 1 << (s - r);
            localparam round_kind_e KIND = (r == 0) ? RK_MIRROR : RK_FIXED;
            localparam int          RUN  = (r == s) ? (2 << s) : 0;
            bsort_round #(
                .LANES      (LANES),
                .KEY_W      (KEY_W),
                .SPAN       (SPAN),
                .KIND       (KIND),
                .SORTED_RUN (RUN)
            ) u_round (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (vld_bus[IDX]),
                .in_keys   (key_bus[IDX]),
                .out_valid (vld_bus[IDX+1]),
                .out_keys  (key_bus[IDX+1])
            );
        end
    end

    assign out_valid = vld_bus[ROUNDS];
    assign out_keys  = key_bus[ROUNDS];

    assert_reset_quiet_R5: assert property (@(posedge clk)
        !rst_n |-> !out_valid);

endmodule

// File: tb/test_bsort16_pipe.sv
module test_bsort16_pipe;

    localparam int LANES = 16;
    localparam int KW    = 32;
    localparam int LAT   = 10;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [LANES*KW-1:0] in_keys = '0;
    logic                out_valid;
    logic [LANES*KW-1:0] out_keys;

    int n_chk  = 0;
    int n_fail = 0;

    logic                vhist [LAT];
    logic [LANES*KW-1:0] exp_q [$];
    string               tag_q [$];
    string               cur_tag = "R1";

    always #2.5 clk = ~clk;

    bsort16_pipe i_bsort16_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_keys   (in_keys),
        .out_valid (out_valid),
        .out_keys  (out_keys)
    );

    function automatic logic [LANES*KW-1:0] ref_sort(input logic [LANES*KW-1:0] v);
        int unsigned a [LANES];
        int unsigned t;
        logic [LANES*KW-1:0] r;
        for (int i = 0; i < LANES; i++) a[i] = v[i*KW +: KW];
        for (int i = 1; i < LANES; i++) begin
            for (int j = i; j > 0 && a[j-1] > a[j]; j--) begin
                t = a[j]; a[j] = a[j-1]; a[j-1] = t;
            end
        end
        for (int i = 0; i < LANES; i++) r[i*KW +: KW] = a[i];
        return r;
    endfunction

    // reference model: bookkeeping on the rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) vhist[i] <= 1'b0;
            exp_q.delete();
            tag_q.delete();
        end else begin
            vhist[0] <= in_valid;
            for (int i = 1; i < LAT; i++) vhist[i] <= vhist[i-1];
            if (in_valid) begin
                exp_q.push_back(ref_sort(in_keys));
                tag_q.push_back(cur_tag);
            end
        end
    end

    // comparison on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            n_chk++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R5: out_valid during reset act=%b exp=0", out_valid);
            end
        end else if (vhist[LAT-1] !== 1'bx) begin
            n_chk++;
            if (out_valid !== vhist[LAT-1]) begin
                n_fail++;
                $display("FAIL R3: out_valid act=%b exp=%b", out_valid, vhist[LAT-1]);
            end
            if (out_valid === 1'b1) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R5: unexpected vector act=%h exp=none", out_keys);
                end else begin
                    logic [LANES*KW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (out_keys !== e) begin
                        n_fail++;
                        $display("FAIL %s/R1/R2: act=%h exp=%h", t, out_keys, e);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic send(input logic [LANES*KW-1:0] v, input string tag);
        @(posedge clk); #1;
        cur_tag  = tag;
        in_valid = 1'b1;
        in_keys  = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_keys  = {LANES{32'hDEAD_BEEF}};
        end
    endtask

    function automatic logic [LANES*KW-1:0] rnd_vec();
        logic [LANES*KW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*KW +: KW] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung act=timeout exp=done");
        finish_run();
    end

    initial begin
        logic [LANES*KW-1:0] v;
        for (int i = 0; i < LAT; i++) vhist[i] = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R5: quiet after reset
        idle(3);

        // R1/R2: random vectors with gaps (R3)
        for (int k = 0; k < 6; k++) begin
            send(rnd_vec(), "R1");
            idle(k % 3);
        end

        // R6: already ascending
        for (int i = 0; i < LANES; i++) v[i*KW +: KW] = 32'(i * 3 + 1);
        send(v, "R6");
        // R7: strictly descending
        for (int i = 0; i < LANES; i++) v[i*KW +: KW] = 32'(1000 - i * 7);
        send(v, "R7");
        // R8: all equal
        send({LANES{32'h1234_5678}}, "R8");
        // R8/R9: duplicates with unsigned extremes
        for (int i = 0; i < LANES; i++) begin
            case (i % 5)
                0: v[i*KW +: KW] = 32'hFFFF_FFFF;
                1: v[i*KW +: KW] = 32'h0000_0000;
                2: v[i*KW +: KW] = 32'h8000_0000;
                3: v[i*KW +: KW] = 32'h7FFF_FFFF;
                default: v[i*KW +: KW] = 32'h0000_0007;
            endcase
        end
        send(v, "R9");
        idle(2);

        // R4: back-to-back burst, entry and exit overlap
        for (int k = 0; k < 24; k++) send(rnd_vec(), "R4");
        // R3: alternating gaps
        for (int k = 0; k < 8; k++) begin
            send(rnd_vec(), "R3");
            idle(1);
        end
        idle(LAT + 4);

        // R5: reset with vectors in flight
        for (int k = 0; k < 5; k++) send(rnd_vec(), "R5");
        idle(2);
        rst_n = 1'b0;
        idle(3);
        #1 rst_n = 1'b1;
        idle(LAT + 4);

        // R1 after reset recovery
        send(rnd_vec(), "R1");
        idle(LAT + 3);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R3: vectors left undelivered act=%0d exp=0", exp_q.size());
        end
        finish_run();
    end

endmodule